// File: doc/BRIEF.md
# Bus Master Latency Timer

This block limits how long a bus initiator may keep a burst going once the arbiter wants the bus back. Software programs a coarse time-out into an 8-bit configuration register. Only the top five bits are stored. Each unit of that field stands for eight bus clocks, so the usable range runs from 0 to 248 clocks. The three low bits always read back as zero.

When the initiator begins a transaction, the down-counter loads the programmed value times eight. It then counts down once per clock for as long as the initiator owns the bus, stops at zero, and raises an expiry flag. The block asks the initiator to end its burst only when the timer has expired and the grant has been withdrawn. If the grant is still present, the initiator may go on past expiry. A register write made during a transaction leaves the running count alone and is used at the next load.

Top module: `bus_latency_timer`

## Requirements
- R1: After reset, the register reads 0x00, and both `timer_expired` and `end_burst` are 0.
- R2: A write stores bits 7:3 of `cfg_wdata`. Bits 2:0 are discarded, so `cfg_rdata[2:0]` is always 0. For example, writing 0xFF reads back as 0xF8, and writing 0x07 reads back as 0x00.
- R3: With field value N (bits 7:3) greater than 0, `timer_expired` rises after the N*8-th clock edge that follows the start edge, provided `bus_owned` stays high. For N=5 it is still low after 39 edges and high after 40.
- R4: The largest field value, 31 (register 0xF8), gives a time-out of 248 clocks.
- R5: With a field value of 0, `timer_expired` is high in the first cycle after the start edge.
- R6: When `bus_owned` is low at a clock edge and no start is requested at that edge, the transaction ends, and `timer_expired` is 0 after that edge.
- R7: `end_burst` is 1 only while `timer_expired` is 1 and `bus_grant` is 0. It stays 0 while the grant is high, and it stays 0 before expiry.
- R8: Once expired, the counter holds at zero, and `timer_expired` stays high while ownership continues.
- R9: A register write during a transaction does not change the running count. The next start loads the new value.
- R10: A `txn_start` that arrives during a count reloads the full time-out and takes priority over the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data; low three bits are zero |
| txn_start | input | 1 | Pulse for one clock when the initiator begins a transaction |
| bus_owned | input | 1 | High while the initiator owns the bus |
| bus_grant | input | 1 | Grant from the arbiter, active high |
| timer_expired | output | 1 | The time-out has elapsed in the current transaction |
| end_burst | output | 1 | Expired and grant removed: the initiator must terminate |

## Verification
A stored field that is wrong shows up at `cfg_rdata` on the cycle after the write. It also moves the expiry edge by a multiple of eight clocks, so the bench checks the clock just before the expected expiry and the clock at which expiry is due. A counter that is off by one, fails to reload, or leaks a mid-transaction write into the running count moves `timer_expired` by at least one cycle, and that cycle is exactly where the scoreboard samples. A faulty hold at zero, a faulty end of ownership, or a wrong gating of the grant shows on `timer_expired` or `end_burst` within one clock of the stimulus.

// File: rtl/blt_pkg.sv
package blt_pkg;
  // Stored time-out field width and log2 of clocks per unit
  localparam int unsigned FIELD_W   = 5;
  localparam int unsigned GRAN_LOG2 = 3;
  localparam int unsigned REG_W     = FIELD_W + GRAN_LOG2;
endpackage

// File: rtl/blt_cfg_reg.sv
module blt_cfg_reg #(
  parameter int unsigned FIELD_W   = blt_pkg::FIELD_W,
  parameter int unsigned GRAN_LOG2 = blt_pkg::GRAN_LOG2,
  localparam int unsigned REG_W    = FIELD_W + GRAN_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic [FIELD_W-1:0] field_o
);

  logic [FIELD_W-1:0] field_q, field_d;

  always_comb begin
    field_d = field_q;
    if (we_i) field_d = wdata_i[REG_W-1:GRAN_LOG2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) field_q <= '0;
    else        field_q <= field_d;
  end

  assign field_o = field_q;
  assign rdata_o = {field_q, {GRAN_LOG2{1'b0}}};

  // R2: written upper bits appear on the read port after the edge
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> rdata_o[REG_W-1:GRAN_LOG2] == $past(wdata_i[REG_W-1:GRAN_LOG2]));

  // R9: without a write the stored field never moves
  assert_field_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(field_o));

endmodule

// File: rtl/blt_down_counter.sv
module blt_down_counter #(
  parameter int unsigned FIELD_W   = blt_pkg::FIELD_W,
  parameter int unsigned GRAN_LOG2 = blt_pkg::GRAN_LOG2,
  localparam int unsigned CNT_W    = FIELD_W + GRAN_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               start_i,
  input  logic               owned_i,
  output logic               expired_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active_q, active_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // Next-state: a start reloads and wins over the decrement
  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    if (start_i) begin
      cnt_d    = {field_i, {GRAN_LOG2{1'b0}}};
      active_d = 1'b1;
    end else if (!owned_i) begin
      active_d = 1'b0;
    end else if (active_q && !cnt_zero) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end

  assign expired_o = active_q && cnt_zero;

  // R3: one step down per owned clock while counting
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && owned_i && !start_i && !cnt_zero) |=> (cnt_q == $past(cnt_q) - ONE));

  // R8: expiry is sticky while ownership continues
  assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && owned_i && !start_i) |=> expired_o);

  // R5: a zero field expires immediately after the start
  assert_zero_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && field_i == '0) |=> expired_o);

  // R6: losing ownership clears expiry
  assert_drop_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!owned_i && !start_i) |=> !expired_o);

  // R10: a start with a nonzero field yields a fresh, unexpired count
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && field_i != '0) |=> !expired_o);

endmodule

// File: rtl/bus_latency_timer.sv
module bus_latency_timer #(
  parameter int unsigned FIELD_W   = blt_pkg::FIELD_W,
  parameter int unsigned GRAN_LOG2 = blt_pkg::GRAN_LOG2,
  localparam int unsigned REG_W    = FIELD_W + GRAN_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             txn_start,
  input  logic             bus_owned,
  input  logic             bus_grant,
  output logic             timer_expired,
  output logic             end_burst
);

  logic [FIELD_W-1:0] field;

  blt_cfg_reg #(.FIELD_W(FIELD_W), .GRAN_LOG2(GRAN_LOG2)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .wdata_i (cfg_wdata),
    .rdata_o (cfg_rdata),
    .field_o (field)
  );

  blt_down_counter #(.FIELD_W(FIELD_W), .GRAN_LOG2(GRAN_LOG2)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .field_i   (field),
    .start_i   (txn_start),
    .owned_i   (bus_owned),
    .expired_o (timer_expired)
  );

  assign end_burst = timer_expired && !bus_grant;

  // R7: a live grant always suppresses termination
  assert_grant_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> !end_burst);

  // R7: termination only follows an elapsed timer
  assert_term_needs_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    end_burst |-> timer_expired);

endmodule

// File: tb/bus_latency_timer_test.sv
module bus_latency_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       txn_start = 1'b0;
  logic       bus_owned = 1'b0;
  logic       bus_grant = 1'b1;
  logic       timer_expired;
  logic       end_burst;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_latency_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .txn_start(txn_start), .bus_owned(bus_owned),
    .bus_grant(bus_grant), .timer_expired(timer_expired), .end_burst(end_burst)
  );

  typedef struct {
    int         at;
    int         kind;   // 0 read data, 1 expired, 2 end_burst
    logic [7:0] val;
    string      req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int at, int kind, logic [7:0] val, string req);
    item_t it;
    it.at = at; it.kind = kind; it.val = val; it.req = req;
    q.push_back(it);
  endtask

  // Monitor: compares due items half a clock after each edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = cfg_rdata;
        1:       act = {7'd0, timer_expired};
        default: act = {7'd0, end_burst};
      endcase
      checks++;
      if (it.at != cyc || act !== it.val) begin
        errors++;
        $display("FAIL %s kind=%0d cycle=%0d/%0d actual=%h expected=%h",
                 it.req, it.kind, cyc, it.at, act, it.val);
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_reg(logic [7:0] d, logic [7:0] exp_rd, string req);
    cfg_we = 1'b1; cfg_wdata = d;
    expect_at(cyc + 1, 0, exp_rd, req);
    step(1);
    cfg_we = 1'b0;
  endtask

  // Start at the next edge; returns the cycle index of the start edge
  task automatic start_txn(output int c0);
    c0 = cyc + 1;
    txn_start = 1'b1; bus_owned = 1'b1;
    step(1);
    txn_start = 1'b0;
  endtask

  task automatic end_txn(string req);
    bus_owned = 1'b0;
    expect_at(cyc + 1, 1, 8'd0, req);
    expect_at(cyc + 1, 2, 8'd0, req);
    step(2);
  endtask

  initial begin
    int c0;
    step(3);
    rst_n = 1'b1;
    expect_at(cyc + 1, 0, 8'h00, "R1");
    expect_at(cyc + 1, 1, 8'd0, "R1");
    expect_at(cyc + 1, 2, 8'd0, "R1");
    step(2);

    write_reg(8'hFF, 8'hF8, "R2");
    write_reg(8'h07, 8'h00, "R2");
    write_reg(8'h2F, 8'h28, "R2");

    // N=5 -> 40 clocks; grant high at expiry, then withdrawn
    bus_grant = 1'b0;
    start_txn(c0);
    expect_at(c0 + 10, 2, 8'd0, "R7");
    expect_at(c0 + 39, 1, 8'd0, "R3");
    expect_at(c0 + 40, 1, 8'd1, "R3");
    step(20);
    bus_grant = 1'b1;
    step(c0 + 40 - cyc);
    expect_at(cyc, 2, 8'd0, "R7");
    step(1);
    bus_grant = 1'b0;
    expect_at(cyc, 2, 8'd1, "R7");
    expect_at(cyc + 6, 1, 8'd1, "R8");
    expect_at(cyc + 6, 2, 8'd1, "R8");
    step(8);
    bus_grant = 1'b1;
    end_txn("R6");

    // maximum field
    write_reg(8'hF8, 8'hF8, "R4");
    start_txn(c0);
    expect_at(c0 + 247, 1, 8'd0, "R4");
    expect_at(c0 + 248, 1, 8'd1, "R4");
    step(c0 + 249 - cyc);
    end_txn("R6");

    // zero field
    write_reg(8'h05, 8'h00, "R5");
    start_txn(c0);
    expect_at(c0, 1, 8'd1, "R5");
    step(2);
    end_txn("R6");

    // write during a transaction
    write_reg(8'h10, 8'h10, "R9");
    start_txn(c0);
    step(3);
    write_reg(8'h08, 8'h08, "R9");
    expect_at(c0 + 15, 1, 8'd0, "R9");
    expect_at(c0 + 16, 1, 8'd1, "R9");
    step(c0 + 17 - cyc);
    end_txn("R6");
    start_txn(c0);
    expect_at(c0 + 7, 1, 8'd0, "R9");
    expect_at(c0 + 8, 1, 8'd1, "R9");
    step(c0 + 9 - cyc);

    // restart mid-count (ownership still held), field 1 -> 8 clocks
    start_txn(c0);
    step(4);
    start_txn(c0);
    expect_at(c0 + 7, 1, 8'd0, "R10");
    expect_at(c0 + 8, 1, 8'd1, "R10");
    step(c0 + 9 - cyc);
    end_txn("R6");

    step(3);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL pending items=%0d expected=0", q.size());
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < WATCHDOG && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule